// File: doc/BRIEF.md
# Serial Configuration Register Writer

This block is the write-only side of a three-wire serial control port. It feeds a bank of 8-bit configuration registers. A host lowers the active-low select line and shifts bytes in, most significant bit first. The block samples the data line on each rising edge of the serial clock. The first byte of every select window is an identification byte that must equal 0x30: a 7-bit device code of 0011000 followed by a direction bit of 0 for write. The second byte sets the register pointer: bit 7 turns on auto-advance, bits 6 and 5 are don't-care, and bits 4..0 select one of 32 registers. Every further byte in the window is stored at the current pointer. When auto-advance is on, the pointer then moves up by one and wraps from 31 back to 0.

The three serial lines are asynchronous to the system clock. Each passes through a two-flop synchronizer, and all edges are detected in the system clock domain. The whole register bank is visible at once on a flat parallel output for the rest of the chip. A sticky flag records the first falling edge of the select line after reset, which tells the surrounding logic that the three-wire mode is active.

Top module: `spi_cfg_writer`

## Requirements
- R1: After a synchronous reset every register reads 0x00 on `reg_view` and `sel_mode_o` is 0.
- R2: `sel_mode_o` becomes 1 after the first falling edge of `cs_n` following reset, and stays 1 until the next reset.
- R3: In a window that starts with the byte 0x30 and then a pointer byte P, the next 8 bits (MSB first, sampled on rising `sclk`) are written to register P[4:0]. Register k occupies `reg_view[8k+7:8k]`.
- R4: When pointer-byte bit 7 is 1, each further data byte goes to the next higher register.
- R5: An auto-advancing burst that passes register 31 continues at register 0.
- R6: When pointer-byte bit 7 is 0, every data byte in the window goes to the same register, so the last one wins and neighbouring registers keep their values.
- R7: If the first byte is not exactly 0x30 (wrong device code, or direction bit 1), no register changes until `cs_n` rises again.
- R8: Raising `cs_n` partway through a byte discards that byte and restarts bit counting. The next window is then decoded from its first bit.
- R9: Pointer-byte bits 6 and 5 have no effect on which register is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| sdin | input | 1 | Serial data, asynchronous |
| reg_view | output | 256 | All 32 registers, register k at bits 8k+7..8k |
| sel_mode_o | output | 1 | Sticky flag set by the first select falling edge after reset |

## Verification
The bench targets these corner cases:
- An auto-advancing burst that crosses register 31. A design that saturates the pointer, or does not wrap it, would write register 31 twice or lose the byte meant for register 0.
- Repeated data bytes with auto-advance off. If the pointer moved anyway, register 8 would be corrupted.
- A pointer byte with both don't-care bits set. A design that decodes them as address bits would write the wrong register.
- A bad identification byte, a read-direction byte, and a window aborted after three bits. If any of these leaked a write, or left stale bits in the shifter, a register would change or the next valid window would be misaligned.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

  typedef enum logic [1:0] {
    FR_CHIP = 2'd0,
    FR_PTR  = 2'd1,
    FR_DATA = 2'd2,
    FR_DROP = 2'd3
  } frame_state_t;

  // Pointer byte layout: auto-advance flag position.
  localparam int unsigned PTR_INCR_BIT = 7;

endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
  parameter int unsigned STAGES    = 2,
  parameter bit          RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= RESET_VAL;
          else     chain_q[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= RESET_VAL;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/spi_cfg_shifter.sv
module spi_cfg_shifter #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_s,
  input  logic              sclk_s,
  input  logic              sdin_s,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              cs_fall
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic              sclk_d;
  logic              cs_d;
  logic [BYTE_W-1:0] shift_q;
  logic              sclk_rise;

  assign sclk_rise = sclk_s & ~sclk_d;
  assign cs_fall   = ~cs_n_s & cs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_n_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q    <= '0;
      bit_cnt    <= '0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
    end else begin
      byte_valid <= 1'b0;
      if (cs_n_s) begin
        shift_q <= '0;
        bit_cnt <= '0;
      end else if (sclk_rise) begin
        shift_q <= {shift_q[BYTE_W-2:0], sdin_s};
        if (bit_cnt == LAST_BIT) begin
          bit_cnt    <= '0;
          byte_valid <= 1'b1;
          byte_data  <= {shift_q[BYTE_W-2:0], sdin_s};
        end else begin
          bit_cnt <= bit_cnt + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/spi_cfg_frame.sv
module spi_cfg_frame
  import spi_cfg_pkg::*;
#(
  parameter int unsigned        BYTE_W    = 8,
  parameter int unsigned        ADDR_W    = 5,
  parameter logic [BYTE_W-1:0]  CHIP_CODE = 8'h30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_s,
  input  logic              cs_fall,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic [ADDR_W-1:0] ptr_q,
  output logic              incr_q,
  output frame_state_t      state_q,
  output logic              mode_q
);

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= 1'b0;
    else if (cs_fall) mode_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= FR_CHIP;
      ptr_q   <= '0;
      incr_q  <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (cs_n_s) begin
        state_q <= FR_CHIP;
      end else if (byte_valid) begin
        unique case (state_q)
          FR_CHIP: state_q <= (byte_data == CHIP_CODE) ? FR_PTR : FR_DROP;
          FR_PTR: begin
            ptr_q   <= byte_data[ADDR_W-1:0];
            incr_q  <= byte_data[PTR_INCR_BIT];
            state_q <= FR_DATA;
          end
          FR_DATA: begin
            wr_en   <= 1'b1;
            wr_addr <= ptr_q;
            wr_data <= byte_data;
            if (incr_q) ptr_q <= ptr_q + ADDR_W'(1);
          end
          default: state_q <= FR_DROP;
        endcase
      end
    end
  end

endmodule

// File: rtl/spi_cfg_regfile.sv
module spi_cfg_regfile #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  output logic [DEPTH*DATA_W-1:0] view
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_view
      assign view[g*DATA_W +: DATA_W] = mem[g];
    end
  endgenerate

endmodule

// File: rtl/spi_cfg_writer.sv
module spi_cfg_writer
  import spi_cfg_pkg::*;
#(
  parameter int unsigned       DATA_W      = 8,
  parameter int unsigned       ADDR_W      = 5,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] CHIP_CODE   = 8'h30,
  localparam int unsigned      NUM_REGS    = 1 << ADDR_W,
  localparam int unsigned      CNT_W       = $clog2(DATA_W)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cs_n,
  input  logic                       sclk,
  input  logic                       sdin,
  output logic [NUM_REGS*DATA_W-1:0] reg_view,
  output logic                       sel_mode_o
);

  logic              cs_n_s, sclk_s, sdin_s;
  logic              byte_valid, cs_fall;
  logic [DATA_W-1:0] byte_data;
  logic [CNT_W-1:0]  bit_cnt;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, ptr_q;
  logic [DATA_W-1:0] wr_data;
  logic              incr_q;
  frame_state_t      fr_state;

  spi_cfg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst(rst), .d_async(cs_n), .q_sync(cs_n_s));
  spi_cfg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_clk (
    .clk(clk), .rst(rst), .d_async(sclk), .q_sync(sclk_s));
  spi_cfg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_din (
    .clk(clk), .rst(rst), .d_async(sdin), .q_sync(sdin_s));

  spi_cfg_shifter #(.BYTE_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .cs_n_s(cs_n_s), .sclk_s(sclk_s), .sdin_s(sdin_s),
    .byte_valid(byte_valid), .byte_data(byte_data), .bit_cnt(bit_cnt),
    .cs_fall(cs_fall));

  spi_cfg_frame #(.BYTE_W(DATA_W), .ADDR_W(ADDR_W), .CHIP_CODE(CHIP_CODE)) u_frame (
    .clk(clk), .rst(rst), .cs_n_s(cs_n_s), .cs_fall(cs_fall),
    .byte_valid(byte_valid), .byte_data(byte_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ptr_q(ptr_q), .incr_q(incr_q), .state_q(fr_state), .mode_q(sel_mode_o));

  spi_cfg_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .view(reg_view));

endmodule

// File: rtl/spi_cfg_writer_chk.sv
module spi_cfg_writer_chk
  import spi_cfg_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned CNT_W  = 3,
  localparam int unsigned NUM_REGS = 1 << ADDR_W
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       cs_n_s,
  input logic                       cs_fall,
  input logic [CNT_W-1:0]           bit_cnt,
  input logic                       wr_en,
  input logic [ADDR_W-1:0]          wr_addr,
  input logic [DATA_W-1:0]          wr_data,
  input logic [ADDR_W-1:0]          ptr_q,
  input logic                       incr_q,
  input frame_state_t               fr_state,
  input logic                       mode,
  input logic [NUM_REGS*DATA_W-1:0] reg_view
);

  // R1
  mode_clear_chk: assert property (@(posedge clk) rst |=> !mode);

  // R2
  mode_sticky_chk: assert property (@(posedge clk) disable iff (rst) mode |=> mode);

  // R2
  mode_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mode) |-> $past(cs_fall));

  // R3
  write_in_data_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(fr_state) == FR_DATA);

  // R3
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> reg_view[$past(wr_addr)*DATA_W +: DATA_W] == $past(wr_data));

  // R4 R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && incr_q) |-> ptr_q == wr_addr + ADDR_W'(1));

  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !incr_q) |-> ptr_q == wr_addr);

  // R7
  drop_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (fr_state == FR_DROP) |-> !wr_en);

  // R8
  cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> bit_cnt == '0);

endmodule

bind spi_cfg_writer spi_cfg_writer_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .cs_n_s(cs_n_s), .cs_fall(cs_fall), .bit_cnt(bit_cnt),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .ptr_q(ptr_q),
  .incr_q(incr_q), .fr_state(fr_state), .mode(sel_mode_o), .reg_view(reg_view)
);

// File: tb/spi_cfg_writer_tb.sv
`timescale 1ns/1ps
module spi_cfg_writer_tb;

  localparam int NREG = 32;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic sdin = 1'b0;
  logic [NREG*8-1:0] reg_view;
  logic sel_mode_o;

  always #2.5 clk = ~clk;

  spi_cfg_writer u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdin(sdin),
    .reg_view(reg_view), .sel_mode_o(sel_mode_o));

  typedef struct {
    int       idx;
    logic [7:0] val;
    string    req;
  } exp_t;

  exp_t       sb_q[$];
  logic [7:0] model [NREG];
  string      cur_req;
  bit         chk_go = 1'b0;
  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push_exp(input int idx, input logic [7:0] val, input string req);
    exp_t e;
    e.idx = idx; e.val = val; e.req = req;
    sb_q.push_back(e);
    model[idx] = val;
  endtask

  // Monitor: pops expected writes and checks the whole bank against the model.
  initial begin
    forever begin
      wait (chk_go);
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(reg_view[e.idx*8 +: 8] == e.val, e.req,
              $sformatf("reg[%0d]", e.idx), reg_view[e.idx*8 +: 8], e.val);
      end
      begin
        int mism = 0;
        int first = -1;
        for (int i = 0; i < NREG; i++)
          if (reg_view[i*8 +: 8] !== model[i]) begin
            mism++;
            if (first < 0) first = i;
          end
        check(mism == 0, cur_req, "bank vs model mismatches", mism, 0);
      end
      chk_go = 1'b0;
    end
  end

  task automatic settle_and_check(input string req);
    cur_req = req;
    wait_clk(12);
    chk_go = 1'b1;
    wait (!chk_go);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      sdin = b[i];
      wait_clk(HALF);
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic begin_win();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic end_win();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic write_burst(input logic [7:0] ptrb, input logic [7:0] d[$]);
    begin_win();
    send_bits(8'h30, 8);
    send_bits(ptrb, 8);
    foreach (d[i]) send_bits(d[i], 8);
    end_win();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    wait_clk(4);
    rst = 1'b0;
    wait_clk(2);
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    sb_q.delete();
  endtask

  initial begin
    #(200000 * 5);
    check(1'b0, "WATCHDOG", "run timed out", 0, 1);
    report();
  end

  initial begin
    do_reset();
    // R1 reset state
    settle_and_check("R1");
    check(sel_mode_o == 1'b0, "R1", "mode after reset", sel_mode_o, 0);
    check(sel_mode_o == 1'b0, "R2", "mode before any select fall", sel_mode_o, 0);

    // R3 single write, R2 mode flag set
    write_burst(8'h05, '{8'hA5});
    push_exp(5, 8'hA5, "R3");
    settle_and_check("R3");
    check(sel_mode_o == 1'b1, "R2", "mode after first select", sel_mode_o, 1);

    // R9 reserved bits ignored
    write_burst(8'h6A, '{8'h3C});
    push_exp(10, 8'h3C, "R9");
    settle_and_check("R9");

    // R4 auto-advance burst
    write_burst(8'h90, '{8'h11, 8'h22, 8'h33, 8'h44});
    push_exp(16, 8'h11, "R4"); push_exp(17, 8'h22, "R4");
    push_exp(18, 8'h33, "R4"); push_exp(19, 8'h44, "R4");
    settle_and_check("R4");

    // R5 wrap past 31
    write_burst(8'h9E, '{8'hE1, 8'hE2, 8'hE3});
    push_exp(30, 8'hE1, "R5"); push_exp(31, 8'hE2, "R5"); push_exp(0, 8'hE3, "R5");
    settle_and_check("R5");

    // R6 no advance: last byte wins, neighbour untouched
    write_burst(8'h07, '{8'h01, 8'h02, 8'h03});
    push_exp(7, 8'h03, "R6"); push_exp(8, 8'h00, "R6");
    settle_and_check("R6");

    // R7 wrong device code
    begin_win(); send_bits(8'h32, 8); send_bits(8'h02, 8); send_bits(8'hFF, 8); end_win();
    push_exp(2, 8'h00, "R7");
    settle_and_check("R7");
    // R7 read direction bit
    begin_win(); send_bits(8'h31, 8); send_bits(8'h03, 8); send_bits(8'hFF, 8); end_win();
    push_exp(3, 8'h00, "R7");
    settle_and_check("R7");

    // R8 aborted byte then clean window
    begin_win(); send_bits(8'h30, 8); send_bits(8'h04, 8); send_bits(8'hFF, 3); end_win();
    push_exp(4, 8'h00, "R8");
    settle_and_check("R8");
    write_burst(8'h04, '{8'h5A});
    push_exp(4, 8'h5A, "R8");
    settle_and_check("R8");

    // R1 R2 reset clears bank and flag
    do_reset();
    settle_and_check("R1");
    check(sel_mode_o == 1'b0, "R2", "mode cleared by reset", sel_mode_o, 0);
    write_burst(8'h01, '{8'h77});
    push_exp(1, 8'h77, "R3");
    settle_and_check("R3");
    check(sel_mode_o == 1'b1, "R2", "mode set again", sel_mode_o, 1);

    report();
  end

endmodule